// File: doc/BRIEF.md
# Wiper Position Store and Recall Sequencer

This block keeps a digital potentiometer's wiper position in a small nonvolatile cell. On each power-up it restores that position to the position counter. It saves the position again when the supply is about to fail, or when the user presses a button. A single store-enable pin sets the store policy. When the pin is held low, saving on supply loss is armed. When the pin is left high, each debounced release of a push button wired to it saves the current position.

After power-good rises, the block waits a settle interval. It then issues a one-cycle recall strobe carrying the stored position, and only after that opens the gate for the wiper buttons. The gate also serves as a guard against misuse of the pin. If the pin was high when the recall happened and later goes low, the buttons stay locked out until the pin comes back high. Each store holds a busy flag for a fixed number of cycles. Store requests that arrive during that time are dropped. The nonvolatile cell is a register that keeps its value while power-good is low and is initialised only by the reset.

Top module: `wiper_store_seq`

## Requirements
- R1: While reset is asserted and after it is released with power-good low, busy, the store write strobe, the recall strobe and the button enable are all 0.
- R2: After power-good rises, the button enable stays 0 for at least SETTLE_CYC cycles. The recall strobe is then high for exactly one cycle, and the button enable is 0 in that cycle.
- R3: The recalled value is the last position written to the cell, or INIT_POS if nothing has been written since reset. Power-good low periods do not change it.
- R4: When the debounced pin is low and supply-low is high during normal operation, one store of the current position is launched.
- R5: Only one automatic store is launched for each power-good session, however long supply-low stays high or however often it toggles. The next recall re-arms it.
- R6: A debounced low-to-high transition of the pin during normal operation launches one store of the current position. An automatic store does not occur while the debounced pin is high.
- R7: The pin is debounced: a level must persist for DEBOUNCE_CYC cycles after a two-flop synchroniser before it counts. Shorter pulses launch no store and do not change the button enable.
- R8: A store raises busy for exactly STORE_CYC cycles. The write strobe is a single-cycle pulse in the first busy cycle, and its data is the position sampled when the store was launched.
- R9: A manual request that arrives while busy is high is dropped. It is not queued.
- R10: If the debounced pin was high at recall, the button enable is 0 while the debounced pin is low and returns to 1 once it is high again.
- R11: If the debounced pin was low at recall, the button enable is 1 in normal operation even though the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; also initialises the nonvolatile cell |
| pwrGood | input | 1 | Supply is up and valid |
| supplyLow | input | 1 | Supply has fallen below the store threshold |
| storeEnPin | input | 1 | Raw store-enable pin, idles high |
| curPos | input | POS_W | Current wiper position from the position counter |
| nvWrEn | output | 1 | Single-cycle write strobe to the nonvolatile cell |
| nvWrData | output | POS_W | Position being written |
| busy | output | 1 | A store cycle is in progress |
| recallLoad | output | 1 | Single-cycle load strobe for the position counter |
| recallPos | output | POS_W | Recalled position |
| btnEnable | output | 1 | Gate for the wiper up and down buttons |

## Verification
The bench holds supply-low high for a long time and also toggles it. A design that re-armed the automatic store on supply-low would write the cell several times during one supply loss. The bench presses the button a second time while a store is still busy. A design that queued the request would show an extra write after busy falls. Short glitches on the pin check that the debounce is really there: a missing or short filter would produce a store or drop the button enable. The bench power-cycles twice with different pin levels and checks the recalled value, the settle delay and the lockout. A wrong value or ordering here would recall stale data, open the buttons before the recall strobe, or leave the buttons open in the misuse case.

// File: rtl/wss_pkg.sv
package wss_pkg;

  typedef enum logic [1:0] {
    PS_OFF    = 2'd0,
    PS_SETTLE = 2'd1,
    PS_RECALL = 2'd2,
    PS_RUN    = 2'd3
  } pwrState_e;

  typedef struct packed {
    logic recall;
    logic store;
  } seqStrobes_t;

endpackage

// File: rtl/wss_pin_filter.sv
module wss_pin_filter #(
  parameter int DEBOUNCE_CYC = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level,
  output logic rise
);
  localparam int CW = $clog2(DEBOUNCE_CYC + 1);

  logic syncA, syncB;
  logic [CW-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b1;
      syncB   <= 1'b1;
      level   <= 1'b1;
      rise    <= 1'b0;
      holdCnt <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      rise  <= 1'b0;
      if (syncB == level) begin
        holdCnt <= '0;
      end else if (holdCnt == CW'(DEBOUNCE_CYC - 1)) begin
        holdCnt <= '0;
        level   <= syncB;
        rise    <= syncB;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  // R7: the filtered level only ever moves to the synchronised value
  a_r7_level_follows_sync: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(level) |-> (level == $past(syncB)));

  // R6: a rise pulse always accompanies a fresh high level
  a_r6_rise_means_high: assert property (@(posedge clk) disable iff (!rstN)
    rise |-> (level && !$past(level)));

endmodule

// File: rtl/wss_control.sv
module wss_control
  import wss_pkg::*;
#(
  parameter int SETTLE_CYC = 12,
  parameter int STORE_CYC  = 60
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrGood,
  input  logic        supplyLow,
  input  logic        aseLevel,
  input  logic        aseRise,
  output seqStrobes_t strobes,
  output logic        busy,
  output logic        btnEnable
);
  localparam int SCW = $clog2(SETTLE_CYC + 1);
  localparam int BCW = $clog2(STORE_CYC + 1);

  pwrState_e      state;
  logic [SCW-1:0] settleCnt;
  logic [BCW-1:0] busyCnt;
  logic           armed;
  logic           manualMode;
  logic           autoReq, manReq, launch;

  always_comb begin
    autoReq        = (state == PS_RUN) && armed && supplyLow && !aseLevel;
    manReq         = (state == PS_RUN) && aseRise;
    launch         = (autoReq || manReq) && !busy;
    strobes.store  = launch;
    strobes.recall = (state == PS_RECALL);
    btnEnable      = (state == PS_RUN) && !(manualMode && !aseLevel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= PS_OFF;
      settleCnt  <= '0;
      armed      <= 1'b0;
      manualMode <= 1'b1;
    end else begin
      unique case (state)
        PS_OFF: begin
          settleCnt <= '0;
          armed     <= 1'b0;
          if (pwrGood) state <= PS_SETTLE;
        end
        PS_SETTLE: begin
          if (!pwrGood) begin
            state <= PS_OFF;
          end else if (settleCnt == SCW'(SETTLE_CYC - 1)) begin
            state <= PS_RECALL;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        PS_RECALL: begin
          manualMode <= aseLevel;
          armed      <= 1'b1;
          state      <= pwrGood ? PS_RUN : PS_OFF;
        end
        PS_RUN: begin
          if (launch && autoReq) armed <= 1'b0;
          if (!pwrGood) state <= PS_OFF;
        end
        default: state <= PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      busyCnt <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      busyCnt <= '0;
    end else if (busy) begin
      if (busyCnt == BCW'(STORE_CYC - 1)) busy <= 1'b0;
      else busyCnt <= busyCnt + 1'b1;
    end
  end

  // R2: the recall strobe lasts one cycle
  a_r2_recall_single: assert property (@(posedge clk) disable iff (!rstN)
    strobes.recall |=> !strobes.recall);

  // R2: no button access while power is not good
  a_r2_off_no_buttons: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> !btnEnable);

  // R5: once the automatic store fires, it stays disarmed while running
  a_r5_disarm_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && state == PS_RUN) |=> !armed);

  // R8: busy never lasts a single cycle only
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

endmodule

// File: rtl/wss_datapath.sv
module wss_datapath
  import wss_pkg::*;
#(
  parameter int POS_W    = 5,
  parameter int INIT_POS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strobes,
  input  logic [POS_W-1:0] curPos,
  output logic             nvWrEn,
  output logic [POS_W-1:0] nvWrData,
  output logic             recallLoad,
  output logic [POS_W-1:0] recallPos
);
  logic [POS_W-1:0] nvCell;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nvCell   <= POS_W'(INIT_POS);
      nvWrEn   <= 1'b0;
      nvWrData <= '0;
    end else begin
      nvWrEn <= strobes.store;
      if (strobes.store) begin
        nvWrData <= curPos;
        nvCell   <= curPos;
      end
    end
  end

  assign recallLoad = strobes.recall;
  assign recallPos  = nvCell;

  // R3: the cell changes only through a store
  a_r3_cell_only_on_store: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(nvCell) |-> $past(strobes.store));

endmodule

// File: rtl/wiper_store_seq.sv
module wiper_store_seq
  import wss_pkg::*;
#(
  parameter int POS_W        = 5,
  parameter int INIT_POS     = 16,
  parameter int DEBOUNCE_CYC = 10_000_000,
  parameter int SETTLE_CYC   = 125_000,
  parameter int STORE_CYC    = 500_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrGood,
  input  logic             supplyLow,
  input  logic             storeEnPin,
  input  logic [POS_W-1:0] curPos,
  output logic             nvWrEn,
  output logic [POS_W-1:0] nvWrData,
  output logic             busy,
  output logic             recallLoad,
  output logic [POS_W-1:0] recallPos,
  output logic             btnEnable
);
  logic        aseLevel, aseRise;
  seqStrobes_t strobes;

  wss_pin_filter #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_filter (
    .clk(clk), .rstN(rstN), .rawIn(storeEnPin), .level(aseLevel), .rise(aseRise)
  );

  wss_control #(.SETTLE_CYC(SETTLE_CYC), .STORE_CYC(STORE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .supplyLow(supplyLow),
    .aseLevel(aseLevel), .aseRise(aseRise), .strobes(strobes),
    .busy(busy), .btnEnable(btnEnable)
  );

  wss_datapath #(.POS_W(POS_W), .INIT_POS(INIT_POS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curPos(curPos),
    .nvWrEn(nvWrEn), .nvWrData(nvWrData), .recallLoad(recallLoad),
    .recallPos(recallPos)
  );

  // R8: the write pulse opens a busy period and carries the launched position
  a_r8_write_with_busy: assert property (@(posedge clk) disable iff (!rstN)
    nvWrEn |-> ($rose(busy) && nvWrData == $past(curPos)));

  // R2: the buttons are still closed during the recall cycle
  a_r2_recall_before_enable: assert property (@(posedge clk) disable iff (!rstN)
    recallLoad |-> !btnEnable);

endmodule

// File: tb/wiper_store_seq_bench.sv
`timescale 1ns/1ps
module wiper_store_seq_bench;
  localparam int POS_W  = 5;
  localparam int INIT   = 16;
  localparam int DEB    = 8;
  localparam int SETTLE = 12;
  localparam int STORE  = 60;

  logic clk = 1'b0;
  logic rstN, pwrGood, supplyLow, storeEnPin;
  logic [POS_W-1:0] curPos;
  logic nvWrEn, busy, recallLoad, btnEnable;
  logic [POS_W-1:0] nvWrData, recallPos;

  int checks = 0;
  int failures = 0;
  int wrCount = 0;
  int lastData = -1;
  int busyRun = 0;
  int lastBusyLen = 0;

  always #2 clk = ~clk;

  wiper_store_seq #(.POS_W(POS_W), .INIT_POS(INIT), .DEBOUNCE_CYC(DEB),
                    .SETTLE_CYC(SETTLE), .STORE_CYC(STORE)) u_wiper_store_seq (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .supplyLow(supplyLow),
    .storeEnPin(storeEnPin), .curPos(curPos), .nvWrEn(nvWrEn),
    .nvWrData(nvWrData), .busy(busy), .recallLoad(recallLoad),
    .recallPos(recallPos), .btnEnable(btnEnable)
  );

  always @(posedge clk) begin
    if (nvWrEn) begin
      wrCount <= wrCount + 1;
      lastData <= int'(nvWrData);
    end
    if (busy) busyRun <= busyRun + 1;
    else if (busyRun != 0) begin
      lastBusyLen <= busyRun;
      busyRun <= 0;
    end
  end

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up(int expRecall, int expEnable, string tag);
    int recalls = 0;
    int recallAt = -1;
    int firstEn = -1;
    int val = -1;
    @(negedge clk);
    pwrGood = 1'b1;
    for (int i = 1; i <= SETTLE + 10; i++) begin
      @(negedge clk);
      if (recallLoad) begin
        recalls++;
        recallAt = i;
        val = int'(recallPos);
        check({tag, " R2 enable low in recall"}, int'(btnEnable), 0);
      end
      if (btnEnable && firstEn < 0) firstEn = i;
    end
    check({tag, " R2 single recall"}, recalls, 1);
    check({tag, " R2 settle wait"}, int'(recallAt >= SETTLE), 1);
    check({tag, " R3 recalled value"}, val, expRecall);
    if (expEnable != 0)
      check({tag, " R2 enable after recall"}, int'(firstEn > recallAt), 1);
    check({tag, " enable state"}, int'(btnEnable), expEnable);
  endtask

  task automatic press(int lowCyc, int highCyc);
    storeEnPin = 1'b0;
    cycles(lowCyc);
    storeEnPin = 1'b1;
    cycles(highCyc);
  endtask

  task automatic test_reset();
    rstN = 1'b0; pwrGood = 1'b0; supplyLow = 1'b0; storeEnPin = 1'b1; curPos = '0;
    cycles(3);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 enable in reset", int'(btnEnable), 0);
    rstN = 1'b1;
    cycles(20);
    check("R1 write idle", wrCount, 0);
    check("R1 recall idle", int'(recallLoad), 0);
    check("R1 enable off", int'(btnEnable), 0);
  endtask

  task automatic test_manual_store();
    int w0;
    curPos = 5'd7;
    w0 = wrCount;
    storeEnPin = 1'b0;
    cycles(20);
    check("R10 lockout while pin low", int'(btnEnable), 0);
    check("R6 no store on falling edge", wrCount, w0);
    storeEnPin = 1'b1;
    cycles(20);
    check("R10 enable back", int'(btnEnable), 1);
    check("R6 one manual store", wrCount, w0 + 1);
    check("R8 write data", lastData, 7);
    cycles(STORE);
    check("R8 busy length", lastBusyLen, STORE);
  endtask

  task automatic test_glitch();
    int w0;
    w0 = wrCount;
    storeEnPin = 1'b0;
    cycles(4);
    check("R7 enable kept during glitch", int'(btnEnable), 1);
    storeEnPin = 1'b1;
    cycles(30);
    check("R7 short pulse no store", wrCount, w0);
    check("R7 enable kept", int'(btnEnable), 1);
  endtask

  task automatic test_busy_drop();
    int w0;
    w0 = wrCount;
    curPos = 5'd9;
    press(14, 14);
    check("R6 store launched", wrCount, w0 + 1);
    check("R9 busy during second press", int'(busy), 1);
    curPos = 5'd3;
    press(14, 14);
    cycles(STORE + 10);
    check("R9 request during busy dropped", wrCount, w0 + 1);
    check("R9 cell keeps first data", lastData, 9);
    curPos = 5'd12;
    press(14, 14);
    check("R6 press after busy stores", wrCount, w0 + 2);
    check("R8 data of later press", lastData, 12);
    cycles(STORE);
  endtask

  task automatic test_no_auto_when_high();
    int w0;
    w0 = wrCount;
    curPos = 5'd21;
    supplyLow = 1'b1;
    cycles(30);
    check("R6 no auto store with pin high", wrCount, w0);
    pwrGood = 1'b0;
    supplyLow = 1'b0;
    storeEnPin = 1'b0;
    cycles(30);
    check("R2 enable off when power lost", int'(btnEnable), 0);
  endtask

  task automatic test_auto_store();
    int w0;
    w0 = wrCount;
    curPos = 5'd25;
    cycles(5);
    check("R11 enable with pin low", int'(btnEnable), 1);
    supplyLow = 1'b1;
    cycles(100);
    check("R4 auto store", wrCount, w0 + 1);
    check("R4 auto data", lastData, 25);
    supplyLow = 1'b0;
    cycles(5);
    curPos = 5'd2;
    supplyLow = 1'b1;
    cycles(STORE + 20);
    check("R5 no second auto store", wrCount, w0 + 1);
    pwrGood = 1'b0;
    supplyLow = 1'b0;
    cycles(20);
  endtask

  task automatic test_rearm();
    int w0;
    power_up(25, 1, "third");
    w0 = wrCount;
    curPos = 5'd30;
    supplyLow = 1'b1;
    cycles(10);
    check("R5 rearmed after recall", wrCount, w0 + 1);
    check("R4 rearmed data", lastData, 30);
    cycles(STORE);
  endtask

  initial begin
    test_reset();
    power_up(INIT, 1, "first");
    test_manual_store();
    test_glitch();
    test_busy_drop();
    test_no_auto_when_high();
    power_up(12, 1, "second");
    test_auto_store();
    test_rearm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule